// File: doc/BRIEF.md
# RTC Timebase Divider

This block turns a 32.768 kHz oscillator, delivered as a one-cycle enable `osc_en_i` in the system clock domain, into the timing pulses a real-time clock needs. A 15-stage binary divider counts oscillator pulses. The rising edge of its top stage gives a one-cycle `tick_1hz_o`, which advances the seconds counter of a calendar unit. A 4-bit rate field selects one of the stages as the source of a sticky periodic flag, `pflag_o`. The flag stays set until software pulses `flag_clr_i`.

A 3-bit control field selects one of three modes. In the counting mode the chain advances. In the clearing mode it is forced to zero. In every other mode the chain keeps its value and the oscillator runs on its own, as it does on backup power. Entering the counting mode from zero places the first 1 Hz tick half a second later. The first periodic flag likewise comes half a period after entry, because every output follows a rising edge of a stage.

All pins carry plain control and status levels or single-cycle events. Nothing streams through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `rtc_divider`

## Requirements
- R1: While `rst_n` is low, `tick_1hz_o` and `pflag_o` are 0, and the chain restarts from zero after release.
- R2: With `div_ctl_i` = 3'b010 the chain advances by exactly one on each cycle where `osc_en_i` is 1, and does not advance on cycles where it is 0.
- R3: Starting from a zero chain in counting mode, `tick_1hz_o` pulses for one cycle, one clock after the 16384th oscillator pulse, and then after every further 32768 pulses.
- R4: With `div_ctl_i` = 3'b110 or 3'b111 the chain is forced to zero, and neither tick nor flag is produced.
- R5: For any other `div_ctl_i` code the chain holds its value and produces neither tick nor flag. Counting later resumes from the held value.
- R6: With `rate_i` = 0 the periodic flag is never set.
- R7: `rate_i` = r (1 to 15) selects stage r-1, which has a period of 2^r oscillator pulses. `pflag_o` is set one clock after each rising edge of that stage, so the first setting comes 2^(r-1) pulses after counting starts from zero.
- R8: `pflag_o` stays set until a cycle with `flag_clr_i` = 1 clears it. A set event in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en_i | input | 1 | One-cycle pulse per 32.768 kHz oscillator period |
| div_ctl_i | input | 3 | Divider mode: 010 count, 11x clear, other codes hold |
| rate_i | input | 4 | Periodic tap select, 0 = off |
| flag_clr_i | input | 1 | Clears the periodic flag |
| tick_1hz_o | output | 1 | One-cycle 1 Hz update pulse |
| pflag_o | output | 1 | Sticky periodic flag |

## Verification
A chain that is off by even one count shows up at the flag within a couple of oscillator pulses when a low rate value is selected. A fault in the upper stages appears only as a shifted 1 Hz tick, half a second or more after entry into counting mode. The bench therefore compares both outputs every cycle against an independent count model. It mixes fast and slow rates, held and cleared phases, and gaps in the oscillator enable. It also runs a full window of 49152 pulses to pin down the first two 1 Hz ticks exactly.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;
  typedef enum logic [1:0] {
    DIV_RUN   = 2'd0,
    DIV_HOLD  = 2'd1,
    DIV_CLEAR = 2'd2
  } div_mode_e;

  localparam logic [2:0] CTL_RUN = 3'b010;
endpackage

// File: rtl/rtc_div_mode_dec.sv
module rtc_div_mode_dec
  import rtc_div_pkg::*;
(
  input  logic [2:0] ctl_i,
  output div_mode_e  mode_o
);
  always_comb begin
    if (ctl_i[2:1] == 2'b11)   mode_o = DIV_CLEAR;
    else if (ctl_i == CTL_RUN) mode_o = DIV_RUN;
    else                       mode_o = DIV_HOLD;
  end
endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_div_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  div_mode_e         mode_i,
  input  logic              osc_en_i,
  output logic [STAGES-1:0] rise_o
);
  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] cnt_nxt;
  logic              step;

  assign step    = (mode_i == DIV_RUN) && osc_en_i;
  assign cnt_nxt = cnt_q + 1'b1;

  for (genvar b = 0; b < STAGES; b++) begin : g_edge
    assign rise_o[b] = step && !cnt_q[b] && cnt_nxt[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (mode_i == DIV_CLEAR) cnt_q <= '0;
    else if (step)                cnt_q <= cnt_nxt;
  end

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == DIV_CLEAR) |=> (cnt_q == '0));
  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == DIV_HOLD) |=> $stable(cnt_q));
  // R2
  idle_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == DIV_RUN && !osc_en_i) |=> $stable(cnt_q));
  // R2
  one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rise_o) <= 1);
endmodule

// File: rtl/rtc_div_pflag.sv
module rtc_div_pflag #(
  parameter int STAGES = 15,
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] rise_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              clr_i,
  output logic              flag_o
);
  logic hit;
  logic flag_q;

  always_comb begin
    hit = 1'b0;
    for (int b = 0; b < STAGES; b++) begin
      if (rate_i == RATE_W'(b + 1) && rise_i[b]) hit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R6
  rate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_i == '0 && !flag_q) |=> !flag_q);
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
endmodule

// File: rtl/rtc_divider.sv
module rtc_divider
  import rtc_div_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int RATE_W = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en_i,
  input  logic [2:0]        div_ctl_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              flag_clr_i,
  output logic              tick_1hz_o,
  output logic              pflag_o
);
  localparam int TOP = STAGES - 1;

  div_mode_e         mode;
  logic [STAGES-1:0] rise;
  logic              tick_q;

  rtc_div_mode_dec u_dec (
    .ctl_i  (div_ctl_i),
    .mode_o (mode)
  );

  rtc_div_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode),
    .osc_en_i (osc_en_i),
    .rise_o   (rise)
  );

  rtc_div_pflag #(.STAGES(STAGES), .RATE_W(RATE_W)) u_pflag (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_i (rise),
    .rate_i (rate_i),
    .clr_i  (flag_clr_i),
    .flag_o (pflag_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= rise[TOP];
  end

  assign tick_1hz_o = tick_q;

  // R3
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);
  // R4
  clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != DIV_RUN) |=> !tick_q);
endmodule

// File: tb/test_rtc_divider.sv
module test_rtc_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en_i = 1'b0;
  logic [2:0] div_ctl_i = 3'b110;
  logic [3:0] rate_i = 4'd0;
  logic       flag_clr_i = 1'b0;
  logic       tick_1hz_o;
  logic       pflag_o;

  always #5 clk = ~clk;

  rtc_divider i_rtc_divider (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_en_i   (osc_en_i),
    .div_ctl_i  (div_ctl_i),
    .rate_i     (rate_i),
    .flag_clr_i (flag_clr_i),
    .tick_1hz_o (tick_1hz_o),
    .pflag_o    (pflag_o)
  );

  typedef struct {
    logic  tick;
    logic  flag;
    string req;
  } exp_t;

  exp_t      sb_q[$];
  int        n_chk = 0;
  int        n_bad = 0;
  int        ticks_seen = 0;
  int        mcnt = 0;
  logic      mflag = 1'b0;
  string     cur_req = "R1";
  bit        done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outputs.
  task automatic step(input logic [2:0] ctl, input logic [3:0] rate,
                      input logic osc, input logic clr);
    exp_t e;
    int   nx;
    logic set;
    @(negedge clk);
    div_ctl_i  = ctl;
    rate_i     = rate;
    osc_en_i   = osc;
    flag_clr_i = clr;
    e.tick = 1'b0;
    set    = 1'b0;
    if (ctl[2:1] == 2'b11) begin
      mcnt = 0;
    end else if (ctl == 3'b010 && osc) begin
      nx = (mcnt + 1) % 32768;
      e.tick = ((mcnt >> 14) & 1) == 0 && ((nx >> 14) & 1) == 1;
      if (rate != 0)
        set = ((mcnt >> (rate - 1)) & 1) == 0 && ((nx >> (rate - 1)) & 1) == 1;
      mcnt = nx;
    end
    mflag  = set ? 1'b1 : (clr ? 1'b0 : mflag);
    e.flag = mflag;
    e.req  = cur_req;
    sb_q.push_back(e);
  endtask

  // Monitor: pops expectations after each edge and compares.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (tick_1hz_o) ticks_seen++;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(tick_1hz_o == e.tick, e.req, "tick_1hz_o", tick_1hz_o, e.tick);
        check(pflag_o == e.flag, e.req, "pflag_o", pflag_o, e.flag);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet during reset
    check(tick_1hz_o == 1'b0, "R1", "tick in reset", tick_1hz_o, 0);
    check(pflag_o == 1'b0, "R1", "flag in reset", pflag_o, 0);
    rst_n = 1'b1;

    // R7 and R8: fast tap, periodic clears
    cur_req = "R7";
    for (int i = 0; i < 40; i++) step(3'b010, 4'd3, 1'b1, (i % 10) == 9);
    cur_req = "R8";
    for (int i = 0; i < 30; i++) step(3'b010, 4'd1, 1'b1, 1'b1);
    for (int i = 0; i < 12; i++) step(3'b010, 4'd4, 1'b1, i == 5);

    // R2: gaps in the oscillator enable
    cur_req = "R2";
    for (int i = 0; i < 60; i++) step(3'b010, 4'd2, (i % 3) == 0, (i % 7) == 6);

    // R5: hold codes freeze the chain, then resume
    cur_req = "R5";
    for (int i = 0; i < 20; i++) step(3'b000, 4'd1, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++) step(3'b101, 4'd2, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) step(3'b010, 4'd5, 1'b1, (i % 8) == 7);

    // R4: both clear codes
    cur_req = "R4";
    for (int i = 0; i < 10; i++) step(3'b110, 4'd1, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++) step(3'b111, 4'd1, 1'b1, 1'b0);
    for (int i = 0; i < 9; i++) step(3'b010, 4'd4, 1'b1, 1'b0);

    // R6: rate zero never flags
    cur_req = "R6";
    step(3'b010, 4'd0, 1'b1, 1'b1);
    for (int i = 0; i < 50; i++) step(3'b010, 4'd0, 1'b1, 1'b0);

    // R3: first two 1 Hz ticks from a cleared chain
    cur_req = "R3";
    step(3'b110, 4'd15, 1'b0, 1'b1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    ticks_seen = 0;
    for (int i = 0; i < 16384 + 32768 + 4; i++) step(3'b010, 4'd15, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check(ticks_seen == 2, "R3", "tick count", ticks_seen, 2);
    check(pflag_o == 1'b1, "R7", "slowest tap flag", pflag_o, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule